// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Engine

This block is the bus-facing half of a small serial EEPROM. It watches a two-wire bus (clock line and open-drain data line) with a faster system clock. Both lines pass through synchronisers. The block recognises bus conditions, shifts words in and out, and answers with acknowledge bits. It drives the data line only through an output enable: a high enable pulls the line low, and a low enable releases it.

A transaction starts with a device byte made of a fixed prefix, three strap bits and a direction bit. After that the master either writes or reads. A write sends a word address followed by any number of data bytes, and each data byte goes to a write unit as a one-cycle strobe. A read streams bytes fetched from a shared address pointer. A stop after written data tells the write unit to begin its internal cycle. While that cycle runs, the engine refuses its device address, so the master can poll until the write has finished. The pointer wraps inside an 8-byte page during writes and across the whole space during reads.

Top module: `tw_eeprom_slave`

## Requirements
- R1: An SDA fall while SCL is high is a start and an SDA rise while SCL is high is a stop. Both are honoured in every state. A start restarts device-byte reception, and a stop returns the engine to idle. A data byte that is cut short by either condition produces no write strobe.
- R2: The first byte after a start is taken MSB first. Its bits 7..4 must equal 1010 and its bits 3..1 must equal strap_i[2:0]. Bit 0 selects read when it is 1. On any mismatch the engine does not acknowledge and ignores the bus until the next start.
- R3: Incoming bits are sampled on the SCL rising edge. Outgoing read bits change only after an SCL falling edge and stay stable while SCL is high.
- R4: The engine pulls SDA low through the whole ninth clock of every accepted device byte, word address and write data byte. At all other times it releases SDA, except while it is sending read data.
- R5: In a write, the second byte loads the pointer. Each following data byte raises wr_stb_o for one cycle, with wr_addr_o equal to the pointer and wr_data_o equal to the byte. The pointer then increments in its low 3 bits only, so it wraps within the current 8-byte page.
- R6: wr_commit_o pulses once at a stop that ends a write carrying at least one complete data byte. A write that ends without data, or that is cut off by a start, gives no pulse.
- R7: Each byte sent in a read comes from the pointer, and the pointer then increments over the full space (0xFF wraps to 0x00). A read with no preceding address therefore continues from the last access plus one.
- R8: A write that carries only a word address, followed by a start and a read device byte, returns the data at that word address.
- R9: After each read byte, a master acknowledge (SDA low on the ninth clock) makes the engine send the next byte. A master no-acknowledge makes it release SDA and wait for a start or stop.
- R10: While wr_busy_i is high, the engine does not acknowledge a matching device byte.
- R11: The sequence start, nine clocks with SDA released, start, stop leaves the engine idle from any state, including the middle of a data byte. The sequence produces no write strobe and no commit.
- R12: After reset, sda_oe is low, no strobe is raised, and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Pin-strapped device address bits |
| wr_busy_i | input | 1 | Write unit is running its internal cycle |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | ADDR_W | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | Stop ended a write carrying data |
| rd_req_o | output | 1 | A read byte is taken this cycle |
| rd_addr_o | output | ADDR_W | Address of the byte to read |
| rd_data_i | input | 8 | Read data for rd_addr_o, same cycle |

## Verification
Every bus edge passes through two synchroniser stages and one edge register. The engine therefore updates its state, and with it sda_oe, about three system clocks after SCL or SDA moves. Write strobes appear in the cycle in which the eighth rising edge is seen, and the commit pulse appears in the cycle in which the stop is detected. The bench changes a line only when a quarter SCL period of ten clocks has elapsed, and it samples the wired-AND line at the start and at the end of each high phase. A per-clock monitor compares every strobe against a queue of expected address and data pairs, and it counts commit pulses for comparison with the reference count.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_HOLD,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tw_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         WORD_W     = 8;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sh[SYNC_STAGES-1];
      sda_prev <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr
);
  localparam int ROW_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] ptr_q, ptr_n, page_inc;

  generate
    if (ROW_W > 0) begin : g_row
      assign page_inc = {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};

      // R5
      page_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load && !inc_full) |=>
          (ptr_q[ADDR_W-1:PAGE_BITS] == $past(ptr_q[ADDR_W-1:PAGE_BITS])));
    end else begin : g_flat
      assign page_inc = ptr_q + ADDR_W'(1);
    end
  endgenerate

  always_comb begin
    ptr_n = ptr_q;
    if (load)          ptr_n = load_val;
    else if (inc_full) ptr_n = ptr_q + ADDR_W'(1);
    else if (inc_page) ptr_n = page_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

  // R7
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BITS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              wr_busy_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int               CNT_W    = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(WORD_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  tw_state_e         state_q, state_n, after_q, after_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n, tx_q, tx_n, rx_byte;
  logic              nak_q, nak_n, pend_q, pend_n;
  logic              ptr_load, ptr_inc_page, ptr_inc_full;
  logic [ADDR_W-1:0] ptr;
  logic              dev_match;

  tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte[ADDR_W-1:0]),
    .inc_page (ptr_inc_page),
    .inc_full (ptr_inc_full),
    .ptr      (ptr)
  );

  assign rx_byte   = {sh_q[WORD_W-2:0], sda_lvl};
  assign dev_match = (rx_byte[7:4] == DEV_PREFIX) && (rx_byte[3:1] == strap_i) && !wr_busy_i;

  always_comb begin
    state_n      = state_q;
    after_n      = after_q;
    cnt_n        = cnt_q;
    sh_n         = sh_q;
    tx_n         = tx_q;
    nak_n        = nak_q;
    pend_n       = pend_q;
    ptr_load     = 1'b0;
    ptr_inc_page = 1'b0;
    ptr_inc_full = 1'b0;
    wr_stb_o     = 1'b0;
    wr_commit_o  = 1'b0;
    rd_req_o     = 1'b0;
    if (start_det) begin
      state_n = ST_DEV;
      cnt_n   = '0;
      pend_n  = 1'b0;
    end else if (stop_det) begin
      state_n     = ST_IDLE;
      wr_commit_o = pend_q;
      pend_n      = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_BIT) begin
              state_n = ST_HOLD;
              if (state_q == ST_DEV) begin
                if (dev_match) after_n = rx_byte[0] ? ST_TX : ST_WADR;
                else           state_n = ST_IDLE;
              end else if (state_q == ST_WADR) begin
                ptr_load = 1'b1;
                after_n  = ST_WDAT;
              end else begin
                wr_stb_o     = 1'b1;
                ptr_inc_page = 1'b1;
                pend_n       = 1'b1;
                after_n      = ST_WDAT;
              end
            end
          end
        end
        ST_HOLD: if (scl_fall) state_n = ST_ACK;
        ST_ACK: begin
          if (scl_fall) begin
            state_n = after_q;
            cnt_n   = '0;
            if (after_q == ST_TX) begin
              tx_n         = rd_data_i;
              rd_req_o     = 1'b1;
              ptr_inc_full = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_n = cnt_q + CNT_W'(1);
          if (scl_fall) begin
            if (cnt_q == ALL_BITS) state_n = ST_MACK;
            else                   tx_n    = {tx_q[WORD_W-2:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise) nak_n = sda_lvl;
          if (scl_fall) begin
            if (nak_q) begin
              state_n = ST_IDLE;
            end else begin
              state_n      = ST_TX;
              cnt_n        = '0;
              tx_n         = rd_data_i;
              rd_req_o     = 1'b1;
              ptr_inc_full = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      nak_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      after_q <= after_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      nak_q   <= nak_n;
      pend_q  <= pend_n;
    end
  end

  assign sda_oe    = (state_q == ST_ACK) || ((state_q == ST_TX) && !tx_q[WORD_W-1]);
  assign wr_addr_o = ptr;
  assign wr_data_o = rx_byte;
  assign rd_addr_o = ptr;

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_DEV) && (cnt_q == '0));

  // R3
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R6
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> stop_det);

  // R10
  busy_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_i |-> !wr_stb_o);
endmodule

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;
  localparam int       Q         = 10;
  localparam int       BUSY_CLKS = 2000;
  localparam logic [2:0] STRAP   = 3'b101;
  localparam logic [7:0] DW      = 8'hAA;
  localparam logic [7:0] DR      = 8'hAB;

  logic       clk, rst_n;
  logic       scl_m, sda_m, line;
  logic       sda_oe, wr_stb_o, wr_commit_o, rd_req_o;
  logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;
  logic       wr_busy;
  int         busy_cnt;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [15:0] exp_q[$];
  int         n_chk, n_err, n_commit, exp_commit;
  bit         done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign line      = sda_m & ~sda_oe;
  assign wr_busy   = (busy_cnt != 0);
  assign rd_data_i = mem[rd_addr_o];

  tw_eeprom_slave u_tw_eeprom_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (line),
    .sda_oe      (sda_oe),
    .strap_i     (STRAP),
    .wr_busy_i   (wr_busy),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_commit_o (wr_commit_o),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // write unit stub: memory and busy timer
  always @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
    end else begin
      if (wr_stb_o) mem[wr_addr_o] <= wr_data_o;
      if (wr_commit_o)       busy_cnt <= BUSY_CLKS;
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of strobes and commits against the reference
  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write strobe", {wr_addr_o, wr_data_o}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({wr_addr_o, wr_data_o} == e, "R5 strobe address/data", {wr_addr_o, wr_data_o}, e);
      end
    end
    if (rst_n && wr_commit_o) n_commit++;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic clock_bit(input logic b, output logic o1, output logic o2);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    o1 = line; wq();
    o2 = line;
    scl_m = 1'b0; wq();
  endtask

  task automatic send_bits(input logic [7:0] v, input int nb);
    logic o1, o2;
    for (int i = 7; i > 7 - nb; i--) begin
      clock_bit(v[i], o1, o2);
      chk(o1 == v[i], "R4 line released while master drives", o1, v[i]);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic o1, o2;
    send_bits(v, 8);
    clock_bit(1'b1, o1, o2);
    acked = (o1 == 1'b0) && (o2 == 1'b0);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] v);
    logic o1, o2;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, o1, o2);
      chk(o1 == o2, "R3 read bit stable while SCL high", o2, o1);
      v = {v[6:0], o1};
    end
    clock_bit(last ? 1'b1 : 1'b0, o1, o2);
  endtask

  task automatic expect_ack(input logic [7:0] v, input bit exp, input string req);
    logic a;
    send_byte(v, a);
    chk(a == exp, req, a, exp);
  endtask

  task automatic wait_ready(output int naks);
    logic a;
    naks = 0;
    for (int t = 0; t < 40; t++) begin
      bus_start();
      send_byte(DW, a);
      bus_stop();
      if (a) break;
      naks++;
    end
  endtask

  task automatic cur_read(input logic [7:0] a, input string req);
    logic [7:0] v;
    bus_start();
    expect_ack(DR, 1'b1, "R2 read device byte acknowledged");
    recv_byte(1'b1, v);
    bus_stop();
    chk(v == ref_mem[a], req, v, ref_mem[a]);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    logic [7:0] v;
    bus_start();
    expect_ack(DW, 1'b1, "R8 dummy write device byte");
    expect_ack(a, 1'b1, "R4 word address acknowledged");
    bus_start();
    expect_ack(DR, 1'b1, "R8 read after repeated start");
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      chk(v == ref_mem[8'(a + k)], req, v, ref_mem[8'(a + k)]);
    end
    bus_stop();
  endtask

  task automatic write_bytes(input logic [7:0] a, input logic [7:0] d[], input string req);
    logic [7:0] p;
    p = a;
    bus_start();
    expect_ack(DW, 1'b1, "R2 write device byte acknowledged");
    expect_ack(a, 1'b1, "R4 word address acknowledged");
    foreach (d[k]) begin
      exp_q.push_back({p, d[k]});
      ref_mem[p] = d[k];
      expect_ack(d[k], 1'b1, req);
      p = {p[7:3], 3'(p[2:0] + 3'd1)};
    end
    bus_stop();
    exp_commit++;
    chk(n_commit == exp_commit, "R6 commit pulse after stop", n_commit, exp_commit);
  endtask

  initial begin
    int naks;
    logic [7:0] v;
    n_chk = 0; n_err = 0; n_commit = 0; exp_commit = 0; done = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = seed(i);
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(sda_oe == 1'b0, "R12 sda_oe low after reset", sda_oe, 0);
    chk(wr_stb_o == 1'b0, "R12 no strobe after reset", wr_stb_o, 0);
    cur_read(8'h00, "R12 first current read from address 0");

    // R2: wrong strap and wrong prefix are refused and the rest ignored
    bus_start();
    expect_ack(8'hA2, 1'b0, "R2 strap mismatch not acknowledged");
    expect_ack(8'h10, 1'b0, "R2 bytes after mismatch ignored");
    bus_stop();
    bus_start();
    expect_ack(8'hBA, 1'b0, "R2 prefix mismatch not acknowledged");
    bus_stop();
    chk(n_commit == 0, "R2 no commit after refused address", n_commit, 0);

    // R5/R6 byte write, then R10 polling
    write_bytes(8'h23, '{8'hC4}, "R5 byte write data acknowledged");
    wait_ready(naks);
    chk(naks >= 1, "R10 device byte refused while busy", naks, 1);
    chk(naks < 40, "R10 device byte accepted after busy", naks, 0);
    chk(n_commit == exp_commit, "R6 polling stop gives no commit", n_commit, exp_commit);

    rand_read(8'h23, 1, "R8 random read returns written byte");
    cur_read(8'h24, "R7 current read continues from last plus one");

    // R5 page wrap
    write_bytes(8'h3D, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, "R5 page write data acknowledged");
    wait_ready(naks);
    rand_read(8'h38, 8, "R9 sequential read over page contents");

    // R9/R7 sequential read across the top of the space
    rand_read(8'hFE, 4, "R7 sequential read wraps FF to 00");
    cur_read(8'h02, "R9 pointer after no-acknowledge");

    // R1 start cuts a data byte short; R6 no commit
    bus_start();
    expect_ack(DW, 1'b1, "R1 write device byte");
    expect_ack(8'h50, 1'b1, "R1 word address");
    send_bits(8'h0F, 4);
    bus_start();
    expect_ack(DR, 1'b1, "R1 device byte after mid-byte start");
    recv_byte(1'b1, v);
    bus_stop();
    chk(v == ref_mem[8'h50], "R1 read after mid-byte start", v, ref_mem[8'h50]);
    chk(n_commit == exp_commit, "R6 no commit after restart", n_commit, exp_commit);

    // R1 stop cuts a data byte short
    bus_start();
    expect_ack(DW, 1'b1, "R1 write device byte");
    expect_ack(8'h60, 1'b1, "R1 word address");
    send_bits(8'h99, 5);
    bus_stop();
    chk(n_commit == exp_commit, "R1 no commit after partial byte", n_commit, exp_commit);
    cur_read(8'h60, "R1 partial byte left memory unchanged");

    // R11 recovery sequence from the middle of a data byte
    bus_start();
    expect_ack(DW, 1'b1, "R11 write device byte");
    expect_ack(8'h70, 1'b1, "R11 word address");
    send_bits(8'hA5, 3);
    bus_start();
    for (int i = 0; i < 9; i++) begin
      logic o1, o2;
      clock_bit(1'b1, o1, o2);
    end
    bus_start();
    bus_stop();
    chk(sda_oe == 1'b0, "R11 line released after recovery", sda_oe, 0);
    chk(n_commit == exp_commit, "R11 no commit from recovery", n_commit, exp_commit);
    cur_read(8'h70, "R11 engine usable after recovery");
    write_bytes(8'h71, '{8'h3C}, "R11 write after recovery acknowledged");
    wait_ready(naks);
    rand_read(8'h71, 1, "R11 read back after recovery");

    chk(exp_q.size() == 0, "R5 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule